// File: doc/BRIEF.md
# Four-Channel Capture Timer with Interval Taps

This block is a 32-bit up-counter that runs freely and wraps. Four capture registers sit beside it. Each capture register copies the counter on an event. The event comes from one of two places: the register's own external pin, or a compare-match pulse shared with a neighbouring 16-bit timer. A per-capture source bit picks between the two. External pins pass through a two-flop synchronizer. A 2-bit edge field on each capture chooses rising edges, falling edges, both, or none.

The counter moves only in cycles where the prescaler strobe `cnt_en` is high. Software can load the counter through a small word-addressed register port with combinational read data.

Four interval taps watch counter bits 10 to 13. When a tap is enabled and its bit goes from 0 to 1, a sticky flag is set and the interrupt output rises. Capture flags are sticky in the same way. Both kinds of flag are cleared by writing 1 to them.

Top module: `cap_timer4`

## Requirements
- R1: Reset leaves the counter, all captures, the control and enable registers, and all flags at zero. After that, the counter rises by exactly one in each cycle where `cnt_en` is high, and holds its value in every other cycle.
- R2: The counter wraps from 0xFFFFFFFF to 0 on an enabled cycle.
- R3: A write to address 0 loads the counter. The write wins over a count in the same cycle.
- R4: When source bit i of the control register (address 5, bits 3:0) is 1, capture i latches the counter in each cycle where `cmp_trig` is high. Its pin is ignored.
- R5: When source bit i is 0, capture i uses pin i after a two-flop synchronizer. Edge field i sits at control bits 5+2i:4+2i. The codes are 01 for rising, 10 for falling, 11 for both, and 00 for none. In this mode `cmp_trig` is ignored.
- R6: Each capture sets its flag `cap_flag[i]`. The flags are read at address 7, bits 3:0. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged.
- R7: Interval enable bit i is at address 6, bit i. When it is set and counter bit 10+i goes from 0 to 1, `itv_flag[i]` is set (address 7, bits 7:4, cleared by writing 1). When the enable bit is clear, the flag stays at 0.
- R8: A read of a capture register (addresses 1 to 4 for A to D) in the cycle its capture fires returns the old value. The new value is visible in the next cycle.
- R9: `irq` is high exactly while at least one interval flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Prescaler count-enable strobe |
| cap_pin | input | 4 | External capture pins, A in bit 0 |
| cmp_trig | input | 1 | Compare-match pulse from the neighbouring timer |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| cap_flag | output | 4 | Sticky capture flags |
| itv_flag | output | 4 | Sticky interval flags |
| irq | output | 1 | Interval interrupt request |

## Verification
The assertions check the following on every cycle:
- The counter holds, steps by one, or takes the written value.
- A capture with the compare-match source holds the counter value from the firing cycle, and the capture raises its flag.
- An interval flag rises only when its enable was set and its tap bit rose.

Some behaviours only the directed scenarios can show. These are the synchronized pin path with each edge code, that a disabled source or edge is ignored, the write-one-to-clear masking, and the old-value read in the firing cycle.

// File: rtl/cap_timer4.sv
module cap_timer4 #(
  parameter int W      = 32,
  parameter int NCAP   = 4,
  parameter int TAP_LO = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [3:0]    cap_pin,
  input  logic          cmp_trig,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [3:0]    cap_flag,
  output logic [3:0]    itv_flag,
  output logic          irq
);
  localparam int CW = NCAP + 2*NCAP;

  logic [W-1:0]    cnt, cnt_nxt;
  logic [W-1:0]    cap_q [NCAP];
  logic [CW-1:0]   ctrl;
  logic [3:0]      itv_en;
  logic [NCAP-1:0] s1, s2, s3, fire;
  logic [3:0]      tap_rise;

  wire wr_cnt  = wr_en && addr == 3'd0;
  wire wr_ctrl = wr_en && addr == 3'd5;
  wire wr_itv  = wr_en && addr == 3'd6;
  wire wr_stat = wr_en && addr == 3'd7;

  assign cnt_nxt  = wr_cnt ? wdata : (cnt_en ? cnt + 1'b1 : cnt);
  assign tap_rise = cnt_nxt[TAP_LO +: 4] & ~cnt[TAP_LO +: 4];
  assign irq      = |itv_flag;

  always_comb
    for (int i = 0; i < NCAP; i++) begin
      fire[i] = ctrl[i] ? cmp_trig
                        : ((s2[i] & ~s3[i] & ctrl[NCAP+2*i]) |
                           (~s2[i] & s3[i] & ctrl[NCAP+2*i+1]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      s1 <= '0; s2 <= '0; s3 <= '0;
      ctrl <= '0; itv_en <= '0;
      cap_flag <= '0; itv_flag <= '0;
      for (int i = 0; i < NCAP; i++) cap_q[i] <= '0;
    end else begin
      cnt <= cnt_nxt;
      s1 <= cap_pin[NCAP-1:0];
      s2 <= s1;
      s3 <= s2;
      if (wr_ctrl) ctrl <= wdata[CW-1:0];
      if (wr_itv) itv_en <= wdata[3:0];
      for (int i = 0; i < NCAP; i++)
        if (fire[i]) cap_q[i] <= cnt;
      cap_flag <= (cap_flag & ~(wr_stat ? wdata[3:0] : 4'h0)) | fire;
      itv_flag <= (itv_flag & ~(wr_stat ? wdata[7:4] : 4'h0)) | (tap_rise & itv_en);
    end

  always_comb
    case (addr)
      3'd0:    rdata = cnt;
      3'd1:    rdata = cap_q[0];
      3'd2:    rdata = cap_q[1];
      3'd3:    rdata = cap_q[2];
      3'd4:    rdata = cap_q[3];
      3'd5:    rdata = {{(W-CW){1'b0}}, ctrl};
      3'd6:    rdata = {{(W-4){1'b0}}, itv_en};
      default: rdata = {{(W-8){1'b0}}, itv_flag, cap_flag};
    endcase

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt) |=> $stable(cnt)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_cnt) |=> cnt == $past(cnt) + 1'b1); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wdata)); // R3

  for (genvar g = 0; g < NCAP; g++) begin : g_chk
    AST_CMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[g] && cmp_trig) |=> cap_q[g] == $past(cnt)); // R4
    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> cap_flag[g]); // R6
    AST_ITV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(itv_flag[g]) |-> ($past(itv_en[g]) && $rose(cnt[TAP_LO+g]))); // R7
  end
endmodule

// File: tb/cap_timer4_bench.sv
module cap_timer4_bench;
  logic clk = 0, rst_n = 0, cnt_en = 0, cmp_trig = 0, wr_en = 0;
  logic [3:0] cap_pin = '0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] cap_flag, itv_flag;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cap_timer4 u_cap_timer4 (.clk, .rst_n, .cnt_en, .cap_pin, .cmp_trig, .wr_en,
    .addr, .wdata, .rdata, .cap_flag, .itv_flag, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 reset count", d, 0);
    rd(3'd1, d); chk("R1 reset capA", d, 0);
    rd(3'd5, d); chk("R1 reset ctrl", d, 0);
    chk("R1 reset flags", {itv_flag, cap_flag, 3'b0, irq}, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(3'd0, 32'd100);
    cnt_en = 1; idle(5); cnt_en = 0;
    rd(3'd0, d); chk("R1 five enabled steps", d, 105);
    idle(3);
    rd(3'd0, d); chk("R1 hold without strobe", d, 105);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    cnt_en = 1; idle(1); cnt_en = 0;
    rd(3'd0, d); chk("R2 wrap to zero", d, 0);
  endtask

  task automatic t_load_prio;
    logic [31:0] d;
    @(negedge clk); cnt_en = 1; wr_en = 1; addr = 3'd0; wdata = 32'h55;
    @(negedge clk); cnt_en = 0; wr_en = 0;
    rd(3'd0, d); chk("R3 write beats count", d, 32'h55);
  endtask

  task automatic t_cmp;
    logic [31:0] d;
    wr(3'd5, 32'h0000_000F);
    wr(3'd0, 32'h1234);
    @(negedge clk); cmp_trig = 1;
    @(negedge clk); cmp_trig = 0;
    for (int i = 1; i <= 4; i++) begin
      rd(3'(i), d); chk("R4 compare capture", d, 32'h1234);
    end
    chk("R6 all capture flags", {28'b0, cap_flag}, 32'hF);
    wr(3'd7, 32'hF);
    chk("R6 flags cleared", {28'b0, cap_flag}, 0);
    cap_pin = 4'hF; idle(6); cap_pin = 4'h0; idle(6);
    chk("R4 pins ignored", {28'b0, cap_flag}, 0);
  endtask

  task automatic t_pins;
    logic [31:0] d;
    wr(3'd5, 32'h390);
    wr(3'd0, 32'h100);
    cap_pin = 4'hF; idle(6);
    chk("R5 rising/both flags", {28'b0, cap_flag}, 32'h5);
    rd(3'd1, d); chk("R5 capA rising", d, 32'h100);
    rd(3'd3, d); chk("R5 capC rising", d, 32'h100);
    rd(3'd2, d); chk("R5 capB ignores rising", d, 32'h1234);
    wr(3'd7, 32'hF);
    wr(3'd0, 32'h200);
    cap_pin = 4'h0; idle(6);
    chk("R5 falling/both flags", {28'b0, cap_flag}, 32'h6);
    rd(3'd1, d); chk("R5 capA ignores falling", d, 32'h100);
    rd(3'd2, d); chk("R5 capB falling", d, 32'h200);
    rd(3'd3, d); chk("R5 capC falling", d, 32'h200);
    rd(3'd4, d); chk("R5 capD edge none", d, 32'h1234);
    wr(3'd7, 32'h1);
    chk("R6 clear only bit0", {28'b0, cap_flag}, 32'h6);
    wr(3'd7, 32'hF);
    @(negedge clk); cmp_trig = 1;
    @(negedge clk); cmp_trig = 0;
    chk("R5 cmp ignored on pin source", {28'b0, cap_flag}, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(3'd5, 32'h1);
    wr(3'd0, 32'h777);
    @(negedge clk); cmp_trig = 1;
    rd(3'd1, d); chk("R8 old value in firing cycle", d, 32'h100);
    @(negedge clk); cmp_trig = 0;
    rd(3'd1, d); chk("R8 new value next cycle", d, 32'h777);
    wr(3'd7, 32'hF);
  endtask

  task automatic t_itv;
    wr(3'd6, 32'h9);
    wr(3'd0, 32'h3FF);
    cnt_en = 1; idle(1); cnt_en = 0;
    chk("R7 tap bit10 flag", {28'b0, itv_flag}, 32'h1);
    chk("R9 irq raised", {31'b0, irq}, 1);
    wr(3'd0, 32'h7FF);
    cnt_en = 1; idle(1); cnt_en = 0;
    chk("R7 disabled tap bit11", {28'b0, itv_flag}, 32'h1);
    wr(3'd0, 32'h1FFF);
    cnt_en = 1; idle(1); cnt_en = 0;
    chk("R7 tap bit13 flag", {28'b0, itv_flag}, 32'h9);
    wr(3'd7, 32'h10);
    chk("R7 clear itv bit0", {28'b0, itv_flag}, 32'h8);
    chk("R9 irq still high", {31'b0, irq}, 1);
    wr(3'd7, 32'h80);
    chk("R9 irq cleared", {31'b0, irq}, 0);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(1);
    t_reset();
    t_count();
    t_wrap();
    t_load_prio();
    t_cmp();
    t_pins();
    t_same_cycle();
    t_itv();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule